// File: doc/BRIEF.md
# Threshold Heartbeat Detector with Rate Measurement

This block watches a stream of filtered, signed signal samples and marks each heartbeat. A beat is declared when a sample goes above a threshold that can be changed at run time. After a beat, the block stays blind for a programmable number of samples, so that a tall T-wave or a noise burst cannot fire it a second time. It then waits until the signal has fallen clearly below the threshold, by a programmable hysteresis margin, before it will accept a new beat.

Each beat gives a single-cycle `beat` pulse and a longer `indicator` pulse that is long enough to drive a buzzer or an LED directly. The block also counts the samples between consecutive beats. A restoring divider, which produces one quotient bit per clock, turns that count into beats per minute and signals the result with a one-cycle strobe. The sample rate is a parameter. Its default of 120 Hz is the rate after decimation.

Top module: `qrs_beat_detect`

## Requirements
- R1: When the detector is armed and a valid sample is strictly greater than `thresh` (both compared as signed), `beat` is high for exactly the one clock cycle that follows the clock edge on which the sample was taken.
- R2: After a beat, the next `inhibit` valid samples are ignored whatever their value. An `inhibit` of 0 skips this lockout.
- R3: After the lockout, the detector arms again only on a valid sample that is strictly below `thresh - hyst`. This difference is computed one bit wider, so it cannot wrap. The sample that re-arms the detector cannot itself produce a beat.
- R4: `indicator` goes high together with `beat` and stays high for STRETCH clock cycles. A new beat reloads the full length.
- R5: The interval is the number of valid samples from the previous beat sample up to and including the current beat sample, so it lies in the range 1 to 2^CW-1. The reported `rate` is floor(60*SAMPLE_HZ / interval).
- R6: `rate_valid` is a single-cycle pulse. It occurs RATE_W clock cycles after the `beat` cycle, where RATE_W = clog2(60*SAMPLE_HZ+1). `rate` takes its new value in that same cycle and does not change at any other time.
- R7: No rate is produced for the first beat after reset. No rate is produced either when the interval has reached 2^CW samples or more; the interval counter saturates at that point.
- R8: After reset, `beat`, `indicator` and `rate_valid` are low, `rate` is 0, and the detector is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A new sample is present this cycle |
| smp | input | SW | Signed filtered sample |
| thresh | input | SW | Signed detection threshold |
| hyst | input | SW | Unsigned hysteresis margin below the threshold |
| inhibit | input | CW | Number of samples ignored after each beat |
| beat | output | 1 | One-cycle beat pulse |
| indicator | output | 1 | Stretched pulse for a buzzer or LED |
| rate | output | RATE_W | Beats per minute |
| rate_valid | output | 1 | One-cycle strobe when `rate` is updated |

## Verification
A corrupted detection state shows at the ports on the very next valid sample. Either a beat appears where the reference model expects none, or an expected beat is missing. A lockout counter that is off by one samples makes the beat move by one sample on patterns where a tall second peak follows the main one. A fault in the interval counter or in the divider shows up RATE_W cycles after the second beat, as a wrong `rate`, a missing strobe, or a strobe on the first beat or after saturation. A wrong stretch count shows within STRETCH cycles on `indicator`.

// File: rtl/qrs_beat_detect.sv
module qrs_beat_detect #(
  parameter int SW        = 12,
  parameter int CW        = 10,
  parameter int SAMPLE_HZ = 120,
  parameter int STRETCH   = 8,
  localparam int DIVIDEND = 60 * SAMPLE_HZ,
  localparam int RATE_W   = $clog2(DIVIDEND + 1),
  localparam int SCW      = $clog2(STRETCH + 1),
  localparam int DCW      = $clog2(RATE_W + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic signed [SW-1:0] smp,
  input  logic signed [SW-1:0] thresh,
  input  logic        [SW-1:0] hyst,
  input  logic        [CW-1:0] inhibit,
  output logic                 beat,
  output logic                 indicator,
  output logic [RATE_W-1:0]    rate,
  output logic                 rate_valid
);

  typedef enum logic [1:0] {ARMED, LOCKOUT, WAIT_LOW} st_t;

  localparam logic [RATE_W-1:0] DVD  = DIVIDEND[RATE_W-1:0];
  localparam logic [CW-1:0]     IMAX = '1;

  st_t              st;
  logic [CW-1:0]    lock_cnt;
  logic [CW-1:0]    ivl;
  logic             have_prev;
  logic [SCW-1:0]   str_cnt;

  logic [CW-1:0]    divisor;
  logic [CW:0]      rem;
  logic [RATE_W-1:0] quo;
  logic [RATE_W-1:0] dsh;
  logic [DCW-1:0]   dcnt;

  logic signed [SW:0] low_lvl;
  logic               above, below, hit, start;
  logic [CW:0]        rs;
  logic               ge;

  assign low_lvl = $signed({thresh[SW-1], thresh}) - $signed({1'b0, hyst});
  assign above   = smp > thresh;
  assign below   = $signed({smp[SW-1], smp}) < low_lvl;
  assign hit     = smp_valid && (st == ARMED) && above;
  assign start   = hit && have_prev && (ivl != IMAX);

  assign indicator = (str_cnt != '0);

  assign rs = {rem[CW-1:0], dsh[RATE_W-1]};
  assign ge = rs >= {1'b0, divisor};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ARMED;
      lock_cnt <= '0;
      beat     <= 1'b0;
    end else begin
      beat <= hit;
      if (smp_valid) begin
        case (st)
          ARMED: if (above) begin
            lock_cnt <= inhibit;
            st       <= (inhibit == '0) ? WAIT_LOW : LOCKOUT;
          end
          LOCKOUT: begin
            lock_cnt <= lock_cnt - CW'(1);
            if (lock_cnt == CW'(1)) st <= WAIT_LOW;
          end
          WAIT_LOW: if (below) st <= ARMED;
          default: st <= ARMED;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          str_cnt <= '0;
    else if (hit)        str_cnt <= SCW'(STRETCH);
    else if (indicator)  str_cnt <= str_cnt - SCW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ivl       <= '0;
      have_prev <= 1'b0;
    end else if (smp_valid) begin
      if (hit) begin
        ivl       <= '0;
        have_prev <= 1'b1;
      end else if (ivl != IMAX) begin
        ivl <= ivl + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divisor    <= '0;
      rem        <= '0;
      quo        <= '0;
      dsh        <= '0;
      dcnt       <= '0;
      rate       <= '0;
      rate_valid <= 1'b0;
    end else begin
      rate_valid <= 1'b0;
      if (start) begin
        divisor <= ivl + CW'(1);
        rem     <= '0;
        quo     <= '0;
        dsh     <= DVD;
        dcnt    <= DCW'(RATE_W);
      end else if (dcnt != '0) begin
        rem  <= ge ? (rs - {1'b0, divisor}) : rs;
        quo  <= {quo[RATE_W-2:0], ge};
        dsh  <= {dsh[RATE_W-2:0], 1'b0};
        dcnt <= dcnt - DCW'(1);
        if (dcnt == DCW'(1)) begin
          rate       <= {quo[RATE_W-2:0], ge};
          rate_valid <= 1'b1;
        end
      end
    end
  end

endmodule

module qrs_beat_detect_chk #(
  parameter int SW     = 12,
  parameter int RATE_W = 13
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_valid,
  input logic signed [SW-1:0] smp,
  input logic signed [SW-1:0] thresh,
  input logic                 beat,
  input logic                 indicator,
  input logic [RATE_W-1:0]    rate,
  input logic                 rate_valid
);

  a_r1_beat_from_high_sample: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> ($past(smp_valid) && ($past(smp) > $past(thresh))));

  a_r1_beat_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> !beat);

  a_r4_indicator_with_beat: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> indicator);

  a_r6_strobe_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rate_valid |=> !rate_valid);

  a_r6_rate_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rate_valid |-> $stable(rate));

endmodule

bind qrs_beat_detect qrs_beat_detect_chk #(.SW(SW), .RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp(smp), .thresh(thresh),
  .beat(beat), .indicator(indicator), .rate(rate), .rate_valid(rate_valid)
);

// File: tb/sim_qrs_beat_detect.sv
module sim_qrs_beat_detect;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 12;
  localparam int CW = 8;
  localparam int SAMPLE_HZ = 120;
  localparam int STRETCH = 4;
  localparam int RATE_W = $clog2(60 * SAMPLE_HZ + 1);
  localparam int IMAX = (1 << CW) - 1;
  localparam int IDLE = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [SW-1:0] smp = '0;
  logic signed [SW-1:0] thresh = '0;
  logic [SW-1:0] hyst = '0;
  logic [CW-1:0] inhibit = '0;
  logic beat, indicator, rate_valid;
  logic [RATE_W-1:0] rate;

  int checks = 0;
  int errors = 0;
  int thr_i, hy_i, inh_i;
  int mstate, mcnt, mivl, ind, pend, exp_rate, last_rate;
  bit mprev;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qrs_beat_detect #(.SW(SW), .CW(CW), .SAMPLE_HZ(SAMPLE_HZ), .STRETCH(STRETCH)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp(smp), .thresh(thresh),
    .hyst(hyst), .inhibit(inhibit), .beat(beat), .indicator(indicator),
    .rate(rate), .rate_valid(rate_valid));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic config_set(input int t, input int h, input int i);
    thr_i = t; hy_i = h; inh_i = i;
    thresh = SW'(t); hyst = SW'(h); inhibit = CW'(i);
  endtask

  task automatic idle_check(input int k);
    bit rv;
    @(posedge clk);
    if (ind > 0) ind--;
    rv = 1'b0;
    if (pend > 0) begin
      pend--;
      rv = (pend == 0);
    end
    @(negedge clk);
    chk(indicator == (ind > 0), "R4 indicator", indicator, ind > 0);
    chk(rate_valid == rv, rv ? "R6 strobe timing" : "R7 no strobe", rate_valid, rv);
    if (rv) begin
      chk(rate == exp_rate, "R5 rate value", rate, exp_rate);
      last_rate = exp_rate;
    end else begin
      chk(rate == last_rate, "R6 rate held", rate, last_rate);
    end
  endtask

  task automatic send(input int v);
    bit eb;
    string tag;
    @(negedge clk);
    smp_valid = 1'b1;
    smp = SW'(v);
    eb = 1'b0;
    tag = (mstate == 0) ? "R1 beat" : (mstate == 1) ? "R2 lockout" : "R3 rearm";
    case (mstate)
      0: if (v > thr_i) eb = 1'b1;
      1: begin mcnt--; if (mcnt == 0) mstate = 2; end
      default: if (v < thr_i - hy_i) mstate = 0;
    endcase
    if (eb) begin
      mstate = (inh_i == 0) ? 2 : 1;
      mcnt = inh_i;
      if (mprev && mivl != IMAX) begin
        pend = RATE_W;
        exp_rate = (60 * SAMPLE_HZ) / (mivl + 1);
      end
      mivl = 0;
      mprev = 1'b1;
    end else if (mivl != IMAX) begin
      mivl++;
    end
    @(posedge clk);
    if (eb) ind = STRETCH;
    else if (ind > 0) ind--;
    @(negedge clk);
    smp_valid = 1'b0;
    chk(beat == eb, tag, beat, eb);
    chk(indicator == (ind > 0), "R4 indicator", indicator, ind > 0);
    chk(rate_valid == 1'b0, "R6 strobe timing", rate_valid, 0);
    for (int k = 1; k <= IDLE; k++) idle_check(k);
  endtask

  initial begin
    mstate = 0; mcnt = 0; mivl = 0; mprev = 1'b0; ind = 0; pend = 0;
    exp_rate = 0; last_rate = 0;
    config_set(500, 100, 2);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(beat == 1'b0, "R8 reset beat", beat, 0);
    chk(indicator == 1'b0, "R8 reset indicator", indicator, 0);
    chk(rate_valid == 1'b0, "R8 reset strobe", rate_valid, 0);
    chk(rate == '0, "R8 reset rate", rate, 0);

    // R1 R2 R3: periodic beats with a tall second peak and a mid-level dip
    for (int p = 2; p <= 8; p += 2) begin
      for (int i = 0; i < 6 * p; i++) begin
        int ph = i % p;
        send(ph == 0 ? 900 : ph == 1 ? 700 : ph == 2 ? 450 : 0);
      end
    end

    // sweep of threshold, hysteresis and inhibit over a pseudo waveform
    for (int c = 0; c < 9; c++) begin
      config_set((c % 3 == 0) ? 500 : (c % 3 == 1) ? -200 : 100,
                 (c / 3 == 0) ? 0 : (c / 3 == 1) ? 150 : 600,
                 c % 4);
      for (int i = 0; i < 60; i++) send(((i * 173 + c * 59) % 1100) - 300);
    end

    // R5 R7: longest reportable interval, then a saturated one
    config_set(500, 100, 1);
    send(-500); send(-500);
    send(900);
    for (int i = 0; i < IMAX - 1; i++) send(0);
    send(900);
    for (int i = 0; i < IMAX + 10; i++) send(0);
    send(900);
    send(0); send(0);
    send(900);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule